// File: doc/BRIEF.md
# Sub-Addressed Two-Wire Command Target with Staged Commit

This block is the two-wire serial target port of a control chip. A bus master writes
configuration bytes into three command registers and reads back one status byte. Each
write names a register with a sub-address and carries one data byte. That byte lands in
a holding register first. The command registers that drive the chip's outputs are loaded
from the holding registers all at once, and only when a STOP condition is seen. A master
can therefore address other devices with repeated STARTs and then switch every setting
at the same moment with a single STOP.

A read returns a single status byte. The block also keeps an interrupt-pending flag.
An internal request sets this flag, and the flag drives an active-low interrupt output.
The flag is cleared only when the master acknowledges the status byte it has read.

SCL and SDA are sampled through two-flop synchronizers. The block uses them in a
design clock domain that runs much faster than SCL.

Top module: `i2c_cmd_target`

## Requirements
- R1: The block acknowledges the address bytes 0x12 (write) and 0x13 (read). An acknowledge is seen as SDA low during the high phase of the ninth SCL clock.
- R2: A write is an address byte, then a sub-address byte, then a data byte. The block acknowledges each of the three bytes.
- R3: Only sub-address bits [1:0] select a register, and bits [7:2] are ignored. For example, sub-address 0x06 writes register 2.
- R4: A write whose sub-address bits [1:0] are 0b11 is acknowledged on all three bytes. It changes no register.
- R5: A written data byte goes into the holding register of the selected register. The command outputs keep their values until a STOP occurs.
- R6: On a STOP, all three holding registers are copied to cmd0_o, cmd1_o and cmd2_o. When a register is written more than once before the STOP, the last write wins. START and STOP are detected as SDA edges while SCL is high: falling for START, rising for STOP.
- R7: After the read address, the block sends status_i MSB first over eight SCL clocks. SDA output changes only while SCL is low. SDA is released for the master's acknowledge. A new START may follow without a STOP.
- R8: irq_req_i high sets the pending flag, and irq_no is low while the flag is pending. If a request and an acknowledge arrive together, the request wins. The flag is cleared only by a master acknowledge (SDA low) of the status byte. A not-acknowledge leaves it pending.
- R9: After reset, cmd0_o, cmd1_o and cmd2_o are 0x00, so the current-limit field cmd0_o[2:0] is 000. After reset irq_no is high and sda_pd_o is low.
- R10: After an address byte other than 0x12 or 0x13, the block gives no acknowledge. It ignores the bus until the next START, so the bytes that follow change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data sensed on the bus |
| sda_pd_o | output | 1 | When high, the open-drain driver pulls SDA low |
| status_i | input | 8 | Status byte returned on a read |
| irq_req_i | input | 1 | Sets the interrupt-pending flag |
| cmd0_o | output | 8 | Command register 0; bits [2:0] are the current-limit field |
| cmd1_o | output | 8 | Command register 1 |
| cmd2_o | output | 8 | Command register 2 |
| irq_no | output | 1 | Active-low interrupt, low while an interrupt is pending |

## Verification
The assertions check four rules on every cycle:
- the SDA pull-down changes only while SCL is low;
- a command output changes only in the cycle after a detected STOP;
- an interrupt request pulls irq_no low on the next cycle;
- irq_no rises only after a master acknowledge of a read.

The bench scenarios cover the behaviour that depends on bus sequences:
- address matching and ignoring a foreign address;
- two-bit sub-address aliasing and the refused sub-address 0b11;
- last-write-wins across repeated STARTs;
- the status byte's bit order;
- a not-acknowledge that keeps the interrupt pending.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;  // idle bus reads high
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int DW       = 8,
  parameter int IDX_W    = 2,
  parameter int NUM_REGS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DW-1:0]    status_i,
  output logic             sda_pd_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             rd_ack_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);
  localparam logic [IDX_W:0] NREG = NUM_REGS[IDX_W:0];

  tgt_state_e      state;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   sh, rd_sh;
  logic            rw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; rd_sh <= '0; rw <= 1'b0;
      sda_pd_o <= 1'b0; wr_en_o <= 1'b0; wr_idx_o <= '0;
      wr_data_o <= '0; rd_ack_o <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      rd_ack_o <= 1'b0;
      if (start_i) begin
        state <= ST_ADDR; cnt <= '0; sda_pd_o <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE; sda_pd_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[DW-2:0], sda_s_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == LAST) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[DW-1:1] == DEV_ADDR) begin
                  sda_pd_o <= 1'b1; rw <= sh[0]; state <= ST_ADDR_ACK;
                end else state <= ST_IDLE;
              end else if (state == ST_SUB) begin
                wr_idx_o <= sh[IDX_W-1:0];
                sda_pd_o <= 1'b1; state <= ST_SUB_ACK;
              end else begin
                sda_pd_o  <= 1'b1; state <= ST_DATA_ACK;
                wr_data_o <= sh;
                wr_en_o   <= ({1'b0, wr_idx_o} < NREG);
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            if (rw) begin
              sda_pd_o <= !status_i[DW-1];
              rd_sh    <= {status_i[DW-2:0], 1'b0};
              cnt      <= '0;
              state    <= ST_RD;
            end else begin
              sda_pd_o <= 1'b0; state <= ST_SUB;
            end
          end
          ST_SUB_ACK: if (scl_fall_i) begin
            sda_pd_o <= 1'b0; state <= ST_DATA;
          end
          ST_DATA_ACK: if (scl_fall_i) begin
            sda_pd_o <= 1'b0; state <= ST_IDLE;
          end
          ST_RD: begin
            if (scl_rise_i) cnt <= cnt + 1'b1;
            else if (scl_fall_i) begin
              if (cnt == LAST) begin
                sda_pd_o <= 1'b0; state <= ST_RD_ACK;
              end else begin
                sda_pd_o <= !rd_sh[DW-1];
                rd_sh    <= {rd_sh[DW-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: if (scl_rise_i) begin
            rd_ack_o <= !sda_s_i;
            state    <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_bank.sv
module i2c_cmd_bank #(
  parameter int NUM_REGS = 3,
  parameter int DW       = 8,
  parameter int IDX_W    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic                          commit_i,
  output logic [NUM_REGS-1:0][DW-1:0]   cmd_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] hold;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold     <= '0;
        cmd_o[g] <= '0;
      end else begin
        if (wr_en_i && wr_idx_i == IDX_W'(g)) hold <= wr_data_i;
        if (commit_i) cmd_o[g] <= hold;
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  input  logic [DW-1:0] status_i,
  input  logic          irq_req_i,
  output logic [DW-1:0] cmd0_o,
  output logic [DW-1:0] cmd1_o,
  output logic [DW-1:0] cmd2_o,
  output logic          irq_no
);
  localparam int NUM_REGS = 3;
  localparam int IDX_W    = 2;

  logic                        scl_s, sda_s;
  logic                        scl_rise, scl_fall, start_det, stop_det;
  logic                        wr_en, rd_ack, irq_pend;
  logic [IDX_W-1:0]            wr_idx;
  logic [DW-1:0]               wr_data;
  logic [NUM_REGS-1:0][DW-1:0] cmd;

  i2c_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2c_bus_events u_evt (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_target_fsm #(
    .DEV_ADDR(DEV_ADDR), .DW(DW), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)
  ) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .status_i, .sda_pd_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .rd_ack_o(rd_ack)
  );

  i2c_cmd_bank #(.NUM_REGS(NUM_REGS), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .commit_i(stop_det), .cmd_o(cmd)
  );

  // new request wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_pend <= 1'b0;
    else if (irq_req_i) irq_pend <= 1'b1;
    else if (rd_ack)    irq_pend <= 1'b0;
  end

  assign irq_no = !irq_pend;
  assign cmd0_o = cmd[0];
  assign cmd1_o = cmd[1];
  assign cmd2_o = cmd[2];
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_pd_o,
  input logic          irq_req_i,
  input logic          irq_no,
  input logic [DW-1:0] cmd0_o,
  input logic [DW-1:0] cmd1_o,
  input logic [DW-1:0] cmd2_o,
  input logic          stop_evt,
  input logic          rd_ack_evt
);
  p_pd_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> !scl_i);

  p_cmd_on_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(cmd0_o) && $stable(cmd1_o) && $stable(cmd2_o)) |-> $past(stop_evt));

  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> !irq_no);

  p_irq_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(rd_ack_evt));
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .irq_req_i(irq_req_i), .irq_no(irq_no), .cmd0_o(cmd0_o),
  .cmd1_o(cmd1_o), .cmd2_o(cmd2_o), .stop_evt(stop_det),
  .rd_ack_evt(rd_ack)
);

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] status_i = 8'h00;
  logic irq_req_i = 1'b0;
  logic sda_pd_o, irq_no;
  logic [7:0] cmd0_o, cmd1_o, cmd2_o;
  wire  sda_bus = sda_m & ~sda_pd_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] hold_m [3];
  logic [7:0] cmd_m  [3];
  logic irq_m = 1'b0;
  logic cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_cmd_target u_dut (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_bus), .sda_pd_o,
    .status_i, .irq_req_i, .cmd0_o, .cmd1_o, .cmd2_o, .irq_no
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-cycle reference compare (R5 R6 R8)
  always @(negedge clk_i) if (cmp_en) begin
    chk("R6 cycle cmd0", cmd0_o, cmd_m[0]);
    chk("R6 cycle cmd1", cmd1_o, cmd_m[1]);
    chk("R6 cycle cmd2", cmd2_o, cmd_m[2]);
    chk("R8 cycle irq_no", irq_no, !irq_m);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_n(Q); scl_m = 1'b1; wait_n(Q); scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_n(Q); scl_m = 1'b1; wait_n(Q/2);
    b = sda_bus; wait_n(Q/2); scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_n(Q); scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q); scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic do_stop();
    cmp_en = 1'b0;
    sda_m = 1'b0; wait_n(Q); scl_m = 1'b1; wait_n(Q); sda_m = 1'b1; wait_n(Q);
    for (int i = 0; i < 3; i++) cmd_m[i] = hold_m[i];
    cmp_en = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack);
  endtask

  task automatic wr_seq(input logic [7:0] addr, input logic [7:0] sub,
                        input logic [7:0] data, input logic exp_ack);
    logic a;
    do_start();
    send_byte(addr, a); chk("R1 write address ack", a, !exp_ack);
    send_byte(sub, a);  chk("R2 sub-address ack", a, !exp_ack);
    send_byte(data, a); chk("R2 data ack", a, !exp_ack);
    if (exp_ack && sub[1:0] != 2'b11) hold_m[sub[1:0]] = data;
  endtask

  task automatic rd_seq(input logic m_ack, output logic [7:0] d);
    logic a;
    do_start();
    send_byte(8'h13, a); chk("R1 read address ack", a, 0);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    cmp_en = 1'b0;
    bit_out(m_ack);
    if (!m_ack) irq_m = 1'b0;
    cmp_en = 1'b1;
  endtask

  task automatic raise_irq();
    cmp_en = 1'b0;
    irq_req_i = 1'b1; wait_n(1); irq_req_i = 1'b0; wait_n(2);
    irq_m = 1'b1;
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 3; i++) begin hold_m[i] = 8'h00; cmd_m[i] = 8'h00; end
    wait_n(4); rst_ni = 1'b1; wait_n(4);
    // R9 reset state
    chk("R9 cmd0 reset", cmd0_o, 8'h00);
    chk("R9 current limit field", cmd0_o[2:0], 3'b000);
    chk("R9 cmd1 reset", cmd1_o, 8'h00);
    chk("R9 cmd2 reset", cmd2_o, 8'h00);
    chk("R9 irq_no reset", irq_no, 1);
    chk("R9 sda released", sda_pd_o, 0);
    cmp_en = 1'b1;

    // R2 R5 R6 single write
    wr_seq(8'h12, 8'h00, 8'hA5, 1'b1);
    wait_n(Q);
    chk("R5 cmd0 held before stop", cmd0_o, 8'h00);
    do_stop();
    chk("R6 cmd0 after stop", cmd0_o, 8'hA5);

    // R3 R6 repeated starts, last write wins
    wr_seq(8'h12, 8'h01, 8'h3C, 1'b1);
    wr_seq(8'h12, 8'h06, 8'h77, 1'b1);
    wr_seq(8'h12, 8'hF9, 8'h11, 1'b1);
    chk("R5 cmd1 held before stop", cmd1_o, 8'h00);
    chk("R5 cmd2 held before stop", cmd2_o, 8'h00);
    do_stop();
    chk("R6 cmd1 last write", cmd1_o, 8'h11);
    chk("R3 cmd2 via sub 0x06", cmd2_o, 8'h77);
    chk("R6 cmd0 kept", cmd0_o, 8'hA5);

    // R4 sub-address 0b11
    wr_seq(8'h12, 8'h03, 8'hEE, 1'b1);
    wr_seq(8'h12, 8'hFF, 8'hDD, 1'b1);
    do_stop();
    chk("R4 cmd0 untouched", cmd0_o, 8'hA5);
    chk("R4 cmd1 untouched", cmd1_o, 8'h11);
    chk("R4 cmd2 untouched", cmd2_o, 8'h77);

    // R10 foreign addresses
    wr_seq(8'h20, 8'h00, 8'h99, 1'b0);
    wr_seq(8'h14, 8'h01, 8'h98, 1'b0);
    do_stop();
    chk("R10 cmd0 unchanged", cmd0_o, 8'hA5);
    chk("R10 cmd1 unchanged", cmd1_o, 8'h11);

    // R7 R8 status read and interrupt
    status_i = 8'h5A;
    raise_irq();
    chk("R8 irq asserted", irq_no, 0);
    rd_seq(1'b1, d);
    chk("R7 status byte 0x5A", d, 8'h5A);
    wait_n(Q);
    chk("R8 nack keeps irq", irq_no, 0);
    status_i = 8'hC3;
    rd_seq(1'b0, d);
    chk("R7 status byte 0xC3", d, 8'hC3);
    wait_n(Q);
    chk("R8 ack clears irq", irq_no, 1);
    chk("R7 sda released after read", sda_pd_o, 0);

    // R7 no stop needed: write follows read directly
    wr_seq(8'h12, 8'h02, 8'h0F, 1'b1);
    do_stop();
    chk("R7 write after read", cmd2_o, 8'h0F);

    wait_n(Q);
    cmp_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule